// File: doc/BRIEF.md
# Transmit Status Interrupt Collector

This block sits beside the transmit side of an Ethernet MAC and turns the per-frame outcome reported by the transmitter into a 32-bit sticky status word. When a frame finishes, the transmitter raises `frm_done` for one cycle. With that pulse it presents the frame's length-field value, the real payload length, the configuration enables that apply, and any reasons the frame was aborted. Deferral and channel-grant notices arrive on their own single-cycle pulses. The block sorts these inputs into cause bits, ORs them into the status word, and drives a level interrupt from every status bit that the mask register does not block.

Software reaches the block through a small word-addressed register port. Address 0 is the status word, and a read of it returns the contents and clears the word in the same access. Address 1 is the mask register. The transmitter, the CRC generator and the DMA engine are all outside this block.

Status bit layout:
- bit 0: CRC error
- bit 1: length mismatch
- bit 2: length out of range
- bit 3: deferral
- bit 4: excessive deferral
- bit 5: excessive collisions
- bit 6: late collision
- bit 7: abort summary
- bit 16: transmit granted

All other bits are reserved.

Top module: `txstat_collector`

## Requirements
- R1: Status bits are sticky. A set bit stays 1 until a status read or a reset, and later events only add bits.
- R2: After reset, status and mask read as 0. A read at address 0 returns the status word on `bus_rdata` one cycle later, and clears the word at the same edge.
- R3: A mask bit of 1 blocks only the interrupt contribution of that bit. The matching status bit is still set and still reads back as 1.
- R4: `irq` is high while any status bit is 1 and its mask bit is 0. It falls in the cycle after the clearing read.
- R5: The abort summary bit 7 is set by a frame with a late collision (which also sets bit 6), excessive collisions (also bit 5), excessive deferral (also bit 4), or oversize. Oversize has no cause bit of its own.
- R6: An oversize abort sets nothing when `huge_en` is 1.
- R7: Length out of range, bit 2, is set when `len_field` > 1500, or when `vlan_pause` is 1.
- R8: Length mismatch, bit 1, is set when `len_field` differs from `data_len` and `len_field` ≤ 1500. It is never set when `len_field` > 1500.
- R9: With `len_chk_en` = 0, neither bit 1 nor bit 2 is set.
- R10: CRC error, bit 0, is set by a finished frame when `pad_en` = 0 and `crc_en` = 0. Otherwise it is not set.
- R11: Bits 31..17 and 15..8 of the status word always read 0.
- R12: If an event arrives in the same cycle as a status read, the read returns the old word, and the new event's bit is held in the status word.
- R13: `defer_evt` sets bit 3 and `grant_evt` sets bit 16. Neither sets bit 7, and neither needs `frm_done`.
- R14: A write at address 1 loads the mask, keeping only bits 16 and 7..0. A read at address 1 returns the mask and does not change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_done | input | 1 | One-cycle pulse when a frame transmission ends |
| len_field | input | 16 | Length/type field value of the frame |
| data_len | input | 16 | Actual data length of the frame |
| vlan_pause | input | 1 | Frame is a VLAN pause control frame |
| huge_en | input | 1 | Frames above the maximum length are allowed |
| len_chk_en | input | 1 | Enable for length-field checking |
| pad_en | input | 1 | Automatic padding enabled |
| crc_en | input | 1 | Automatic CRC append enabled |
| ab_oversize | input | 1 | Frame exceeded the configured maximum length |
| ab_late | input | 1 | Late collision detected |
| ab_excol | input | 1 | Collision retry limit exceeded |
| ab_exdef | input | 1 | Excessive deferral detected |
| defer_evt | input | 1 | One-cycle pulse when a transmission was deferred |
| grant_evt | input | 1 | One-cycle pulse when transmission was granted |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address (0 status, 1 mask) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |

## Verification
The length logic is driven with four kinds of frame:
- A matching length at or below 1500, which must set nothing.
- A mismatched length, which must set only bit 1.
- A length above 1500 that also mismatches, which must set only bit 2. This separates the precedence rule from a plain compare.
- A VLAN pause frame with a matching length, which isolates the second trigger of bit 2.

Each abort cause is tried alone, so that cause-bit mapping errors are told apart from summary-bit errors. The oversize cause is tried with both `huge_en` values. Collisions between events and reads, and between masks and pending bits, are covered as follows:
- An event in the same cycle as a read shows whether the event is lost.
- A masked pending bit shows whether the mask blocks recording or only the interrupt.

// File: rtl/txstat_collector.sv
module txstat_collector #(
  parameter int LEN_W         = 16,
  parameter int MAX_LEN_FIELD = 1500,
  parameter int ADDR_W        = 2,
  parameter int DW            = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  len_field,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              vlan_pause,
  input  logic              huge_en,
  input  logic              len_chk_en,
  input  logic              pad_en,
  input  logic              crc_en,
  input  logic              ab_oversize,
  input  logic              ab_late,
  input  logic              ab_excol,
  input  logic              ab_exdef,
  input  logic              defer_evt,
  input  logic              grant_evt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam int B_CRC = 0;
  localparam int B_MIS = 1;
  localparam int B_RNG = 2;
  localparam int B_DEF = 3;
  localparam int B_XDF = 4;
  localparam int B_XCL = 5;
  localparam int B_LCL = 6;
  localparam int B_ABT = 7;
  localparam int B_GNT = 16;
  localparam logic [DW-1:0] IMPL = (DW'(1) << B_GNT) | DW'(8'hFF);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);

  logic [DW-1:0] status_q, mask_q, ev_bits;

  wire len_big  = len_field > LEN_W'(MAX_LEN_FIELD);
  wire rd_stat  = bus_sel & ~bus_wr & (bus_addr == A_STAT);
  wire wr_mask  = bus_sel &  bus_wr & (bus_addr == A_MASK);
  wire chk      = frm_done & len_chk_en;
  wire oversize = frm_done & ab_oversize & ~huge_en;

  always_comb begin
    ev_bits        = '0;
    ev_bits[B_CRC] = frm_done & ~pad_en & ~crc_en;
    ev_bits[B_MIS] = chk & ~len_big & (len_field != data_len);
    ev_bits[B_RNG] = chk & (len_big | vlan_pause);
    ev_bits[B_DEF] = defer_evt;
    ev_bits[B_XDF] = frm_done & ab_exdef;
    ev_bits[B_XCL] = frm_done & ab_excol;
    ev_bits[B_LCL] = frm_done & ab_late;
    ev_bits[B_ABT] = oversize | (frm_done & (ab_late | ab_excol | ab_exdef));
    ev_bits[B_GNT] = grant_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= '0;
      mask_q    <= '0;
      bus_rdata <= '0;
    end else begin
      status_q <= (rd_stat ? ev_bits : (status_q | ev_bits)) & IMPL;
      if (wr_mask)
        mask_q <= bus_wdata & IMPL;
      if (bus_sel && !bus_wr)
        bus_rdata <= (bus_addr == A_STAT) ? status_q :
                     (bus_addr == A_MASK) ? mask_q : '0;
    end
  end

  assign irq = |(status_q & ~mask_q);
endmodule

module txstat_collector_chk #(
  parameter int ADDR_W = 2,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_done,
  input logic              ab_late,
  input logic              defer_evt,
  input logic              grant_evt,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     status_q,
  input logic              irq
);
  localparam logic [DW-1:0] RSV = ~((DW'(1) << 16) | DW'(8'hFF));
  wire rd0   = bus_sel && !bus_wr && bus_addr == '0;
  wire quiet = !frm_done && !defer_evt && !grant_evt;

  // R1
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0 |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R2
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && quiet |=> status_q == '0);

  // R4
  irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && quiet |=> !irq);

  // R5
  late_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && ab_late |=> status_q[7] && status_q[6]);

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & RSV) == '0);

  // R12
  grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && grant_evt |=> status_q[16]);

  // R13
  no_side_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done && rd0 |=> !status_q[7]);
endmodule

bind txstat_collector txstat_collector_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .ab_late(ab_late),
  .defer_evt(defer_evt), .grant_evt(grant_evt), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .status_q(status_q), .irq(irq)
);

// File: tb/tb_txstat_collector.sv
module tb_txstat_collector;
  logic clk = 0, rst_n = 0;
  logic frm_done = 0, vlan_pause = 0, huge_en = 0, len_chk_en = 1;
  logic pad_en = 1, crc_en = 1;
  logic ab_oversize = 0, ab_late = 0, ab_excol = 0, ab_exdef = 0;
  logic defer_evt = 0, grant_evt = 0, bus_sel = 0, bus_wr = 0;
  logic [15:0] len_field = 16'd64, data_len = 16'd64;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, rd;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txstat_collector dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic wr_mask(input logic [31:0] v);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = v;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse_frame();
    frm_done = 1; @(negedge clk); frm_done = 0;
    len_field = 64; data_len = 64; vlan_pause = 0; huge_en = 0; len_chk_en = 1;
    pad_en = 1; crc_en = 1; ab_oversize = 0; ab_late = 0; ab_excol = 0; ab_exdef = 0;
  endtask

  task automatic t_reset();
    rd_reg(0, rd); check("R2 reset status", rd, 0);
    rd_reg(1, rd); check("R2 reset mask", rd, 0);
    check("R4 reset irq", {31'b0, irq}, 0);
  endtask

  task automatic t_length();
    pulse_frame(); rd_reg(0, rd); check("R8 matching frame clean", rd, 0);
    data_len = 100; pulse_frame(); rd_reg(0, rd); check("R8 mismatch bit1", rd, 32'h2);
    len_field = 1501; data_len = 60; pulse_frame(); rd_reg(0, rd); check("R7 R8 >1500 bit2 only", rd, 32'h4);
    len_field = 1500; data_len = 1500; pulse_frame(); rd_reg(0, rd); check("R7 exactly 1500", rd, 0);
    vlan_pause = 1; pulse_frame(); rd_reg(0, rd); check("R7 vlan pause bit2", rd, 32'h4);
    len_chk_en = 0; len_field = 2000; data_len = 5; pulse_frame();
    len_chk_en = 0; data_len = 7; pulse_frame(); rd_reg(0, rd); check("R9 check disabled", rd, 0);
  endtask

  task automatic t_crc();
    pad_en = 0; crc_en = 0; pulse_frame(); rd_reg(0, rd); check("R10 crc bit0", rd, 32'h1);
    pad_en = 1; crc_en = 0; pulse_frame(); rd_reg(0, rd); check("R10 pad on no crc bit", rd, 0);
  endtask

  task automatic t_abort();
    ab_late = 1; pulse_frame(); rd_reg(0, rd); check("R5 late", rd, 32'hC0);
    ab_excol = 1; pulse_frame(); rd_reg(0, rd); check("R5 excol", rd, 32'hA0);
    ab_exdef = 1; pulse_frame(); rd_reg(0, rd); check("R5 exdef", rd, 32'h90);
    ab_oversize = 1; pulse_frame(); rd_reg(0, rd); check("R5 oversize", rd, 32'h80);
    ab_oversize = 1; huge_en = 1; pulse_frame(); rd_reg(0, rd); check("R6 huge suppresses", rd, 0);
  endtask

  task automatic t_side();
    defer_evt = 1; @(negedge clk); defer_evt = 0;
    grant_evt = 1; @(negedge clk); grant_evt = 0;
    rd_reg(0, rd); check("R13 defer grant no abort", rd, 32'h0001_0008);
    check("R11 reserved zero", rd & 32'hFFFE_FF00, 0);
  endtask

  task automatic t_sticky_irq();
    ab_late = 1; pulse_frame();
    check("R4 irq after event", {31'b0, irq}, 1);
    pad_en = 0; crc_en = 0; pulse_frame();
    @(negedge clk);
    check("R1 irq holds", {31'b0, irq}, 1);
    bus_sel = 1; bus_wr = 0; bus_addr = 0;
    @(negedge clk); bus_sel = 0;
    check("R4 irq drops after read", {31'b0, irq}, 0);
    rd = bus_rdata;
    check("R1 accumulated", rd, 32'hC1);
  endtask

  task automatic t_mask();
    wr_mask(32'hFFFF_FFFF);
    rd_reg(1, rd); check("R14 mask implemented bits", rd, 32'h0001_00FF);
    defer_evt = 1; @(negedge clk); defer_evt = 0;
    check("R3 masked no irq", {31'b0, irq}, 0);
    rd_reg(1, rd); check("R14 mask read keeps status", {31'b0, irq}, 0);
    rd_reg(0, rd); check("R3 masked bit recorded", rd, 32'h8);
    wr_mask(32'h0001_0000);
    defer_evt = 1; @(negedge clk); defer_evt = 0;
    check("R3 unmasked bit irq", {31'b0, irq}, 1);
    rd_reg(0, rd); wr_mask(0);
  endtask

  task automatic t_collide();
    ab_excol = 1; pulse_frame();
    bus_sel = 1; bus_wr = 0; bus_addr = 0; grant_evt = 1;
    @(negedge clk); bus_sel = 0; grant_evt = 0;
    @(negedge clk);
    check("R12 read returns old", bus_rdata, 32'hA0);
    rd_reg(0, rd); check("R12 new event kept", rd, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_length(); t_crc(); t_abort(); t_side();
    t_sticky_irq(); t_mask(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule